// File: doc/BRIEF.md
# Fused Micro-op Tracking Window

This block is a small in-order-retire window. Each entry carries a pair of micro-ops that the decoder has bound together. A single allocation places a decoded item into the next free entry at the tail. The item is tagged as one of three kinds. A plain item uses only its first half. A fused store uses an address half and a data half. A fused load-op uses a load half and an operation half. The two halves leave the window separately. The first half always goes out on issue port A. The second half always goes out on issue port B. Each port then reports completion for its half on its own completion port.

Store halves have no ordering between them and may be offered in the same cycle. The operation half of a load-op waits until completion of its load half has been recorded. An entry leaves the window as a single unit, from the head, once both halves are done. A flush empties the window in one cycle. The depth must be a power of two, because the pointers wrap naturally.

Top module: `fuse_window`

## Requirements
- R1: An item is written when `alloc_valid` and `alloc_ready` are both high at a clock edge. `alloc_ready` is low while DEPTH entries are held, and no further item is accepted in that state.
- R2: The kind encoding is 0 = plain, 1 = fused store, 2 = fused load-op. A plain entry is offered only on port A. Its second half counts as done from allocation onward.
- R3: For a fused store, both halves are offered in the same cycle once the entry is held. Neither half waits on the other.
- R4: For a fused load-op, port B does not offer the operation half until the cycle after port A has reported completion of the load half.
- R5: A half that has been accepted (issue valid and ready at the same edge) is not offered again.
- R6: The head entry retires, with `retire_valid` high together with its tag and kind, only when both of its halves are done. Entries retire one per cycle, in allocation order.
- R7: A head entry that has an unfinished half blocks retirement, even when younger entries are complete.
- R8: Each port offers the oldest eligible entry, counting from the head.
- R9: `flush` empties the window in one cycle. On the next cycle `alloc_ready` is high, nothing is offered, and nothing retires. The next allocation goes to index 0.
- R10: After reset the window is empty: `alloc_ready` is high and every issue and retire valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear all entries and pointers |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 2 | Item kind (0 plain, 1 store, 2 load-op) |
| alloc_tag | input | TAG_W | Tag returned at retirement |
| alloc_ready | output | 1 | Window has a free entry |
| issue_a_valid | output | 1 | Port A offers a first half |
| issue_a_idx | output | IDX_W | Entry index offered on port A |
| issue_a_ready | input | 1 | Port A accepts the offer |
| issue_b_valid | output | 1 | Port B offers a second half |
| issue_b_idx | output | IDX_W | Entry index offered on port B |
| issue_b_ready | input | 1 | Port B accepts the offer |
| complete_a_valid | input | 1 | First half of an entry has finished |
| complete_a_idx | input | IDX_W | Entry whose first half finished |
| complete_b_valid | input | 1 | Second half of an entry has finished |
| complete_b_idx | input | IDX_W | Entry whose second half finished |
| retire_valid | output | 1 | Head entry retires this cycle |
| retire_tag | output | TAG_W | Tag of the retiring entry |
| retire_kind | output | 2 | Kind of the retiring entry |

## Verification
The assertions rely on the following input behaviour:
- Completion is reported only for a half that was previously accepted on the same port, in an entry that is still held.
- Each half is completed at most once.
- `alloc_kind` is never 3.

The stimulus acts as both execution ports and keeps to these rules. It completes only indices it has seen accepted, and only once each. It raises `flush` only in cycles where the head cannot retire, so that the expected retirement queue is cleared together with the window.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  typedef enum logic [1:0] {
    UK_PLAIN = 2'd0,
    UK_STORE = 2'd1,
    UK_LDOP  = 2'd2
  } uop_kind_e;
endpackage

// File: rtl/fuse_pick.sv
// Oldest-first selector: lowest offset from base with a request wins.
module fuse_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] req,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    logic [IDX_W-1:0] pos;
    found = 1'b0;
    idx   = base;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      pos = base + IDX_W'(k);
      if (req[pos]) begin
        found = 1'b1;
        idx   = pos;
      end
    end
  end

  // R8: a reported choice is always a live request
  p_pick_live_r8: assert property (@(posedge clk) disable iff (rst)
    found |-> req[idx]);
endmodule

// File: rtl/fuse_slot.sv
// State of one window entry: kind plus issued/done flags per half.
module fuse_slot
  import fuse_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clear,
  input  logic      alloc_we,
  input  uop_kind_e alloc_kind,
  input  logic      iss_a,
  input  logic      iss_b,
  input  logic      cmp_a,
  input  logic      cmp_b,
  input  logic      retire,
  output logic      valid,
  output uop_kind_e kind,
  output logic      a_iss,
  output logic      a_done,
  output logic      b_iss,
  output logic      b_done
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid  <= 1'b0;
      kind   <= UK_PLAIN;
      a_iss  <= 1'b0;
      a_done <= 1'b0;
      b_iss  <= 1'b0;
      b_done <= 1'b0;
    end else if (alloc_we) begin
      valid  <= 1'b1;
      kind   <= alloc_kind;
      a_iss  <= 1'b0;
      a_done <= 1'b0;
      b_iss  <= (alloc_kind == UK_PLAIN);
      b_done <= (alloc_kind == UK_PLAIN);
    end else begin
      if (retire) valid  <= 1'b0;
      if (iss_a)  a_iss  <= 1'b1;
      if (iss_b)  b_iss  <= 1'b1;
      if (cmp_a)  a_done <= 1'b1;
      if (cmp_b)  b_done <= 1'b1;
    end
  end

  // R5: a done half was issued earlier
  p_done_issued_r5: assert property (@(posedge clk) disable iff (rst || clear)
    (valid && a_done) |-> a_iss);
endmodule

// File: rtl/fuse_tag_ram.sv
// Tag storage: one write port at the tail, one read port at the head.
module fuse_tag_ram #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int W     = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fuse_window.sv
module fuse_window
  import fuse_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc_valid,
  input  logic [1:0]       alloc_kind,
  input  logic [TAG_W-1:0] alloc_tag,
  output logic             alloc_ready,
  output logic             issue_a_valid,
  output logic [IDX_W-1:0] issue_a_idx,
  input  logic             issue_a_ready,
  output logic             issue_b_valid,
  output logic [IDX_W-1:0] issue_b_idx,
  input  logic             issue_b_ready,
  input  logic             complete_a_valid,
  input  logic [IDX_W-1:0] complete_a_idx,
  input  logic             complete_b_valid,
  input  logic [IDX_W-1:0] complete_b_idx,
  output logic             retire_valid,
  output logic [TAG_W-1:0] retire_tag,
  output logic [1:0]       retire_kind
);
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  logic [DEPTH-1:0] s_valid, s_a_iss, s_a_done, s_b_iss, s_b_done;
  uop_kind_e        s_kind [DEPTH];
  logic [DEPTH-1:0] req_a, req_b;

  logic alloc_fire, fire_a, fire_b;

  assign alloc_ready = (count != CNT_W'(DEPTH));
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign fire_a      = issue_a_valid && issue_a_ready;
  assign fire_b      = issue_b_valid && issue_b_ready;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      fuse_slot u_slot (
        .clk        (clk),
        .rst        (rst),
        .clear      (flush),
        .alloc_we   (alloc_fire && (tail == IDX_W'(gi))),
        .alloc_kind (uop_kind_e'(alloc_kind)),
        .iss_a      (fire_a && (issue_a_idx == IDX_W'(gi))),
        .iss_b      (fire_b && (issue_b_idx == IDX_W'(gi))),
        .cmp_a      (complete_a_valid && (complete_a_idx == IDX_W'(gi))),
        .cmp_b      (complete_b_valid && (complete_b_idx == IDX_W'(gi))),
        .retire     (retire_valid && (head == IDX_W'(gi))),
        .valid      (s_valid[gi]),
        .kind       (s_kind[gi]),
        .a_iss      (s_a_iss[gi]),
        .a_done     (s_a_done[gi]),
        .b_iss      (s_b_iss[gi]),
        .b_done     (s_b_done[gi])
      );
      assign req_a[gi] = s_valid[gi] && !s_a_iss[gi];
      assign req_b[gi] = s_valid[gi] && !s_b_iss[gi] &&
                         ((s_kind[gi] != UK_LDOP) || s_a_done[gi]);
    end
  endgenerate

  fuse_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick_a (
    .clk (clk), .rst (rst), .req (req_a), .base (head),
    .found (issue_a_valid), .idx (issue_a_idx)
  );

  fuse_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick_b (
    .clk (clk), .rst (rst), .req (req_b), .base (head),
    .found (issue_b_valid), .idx (issue_b_idx)
  );

  fuse_tag_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W), .W(TAG_W)) u_tags (
    .clk (clk), .we (alloc_fire), .waddr (tail), .wdata (alloc_tag),
    .raddr (head), .rdata (retire_tag)
  );

  assign retire_valid = s_valid[head] && s_a_done[head] && s_b_done[head];
  assign retire_kind  = s_kind[head];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)   tail <= tail + 1'b1;
      if (retire_valid) head <= head + 1'b1;
      count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_valid);
    end
  end

  // R1: occupancy never exceeds the depth
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R4: operation half of a load-op only offered after its load completed
  p_ldop_order_r4: assert property (@(posedge clk) disable iff (rst)
    (issue_b_valid && s_kind[issue_b_idx] == UK_LDOP) |-> s_a_done[issue_b_idx]);

  // R5: an accepted half is never offered again
  p_no_reissue_r5: assert property (@(posedge clk) disable iff (rst)
    issue_a_valid |-> !s_a_iss[issue_a_idx]);

  // R6: a retirement advances the head by exactly one
  p_retire_head_r6: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && !flush) |=> (head == IDX_W'($past(head) + 1'b1)));

  // R9: after a flush the window is empty
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0) && !retire_valid && !issue_a_valid);
endmodule

// File: tb/fuse_window_tb.sv
module fuse_window_tb;
  localparam int DEPTH = 8;
  localparam int TAG_W = 6;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic alloc_valid = 1'b0;
  logic [1:0] alloc_kind = 2'd0;
  logic [TAG_W-1:0] alloc_tag = '0;
  logic alloc_ready;
  logic issue_a_valid, issue_b_valid;
  logic [IDX_W-1:0] issue_a_idx, issue_b_idx;
  logic issue_a_ready = 1'b0, issue_b_ready = 1'b0;
  logic complete_a_valid = 1'b0, complete_b_valid = 1'b0;
  logic [IDX_W-1:0] complete_a_idx = '0, complete_b_idx = '0;
  logic retire_valid;
  logic [TAG_W-1:0] retire_tag;
  logic [1:0] retire_kind;

  int checks = 0;
  int failures = 0;
  logic [TAG_W+1:0] exp_q [$];
  logic [IDX_W-1:0] ia, ib;

  always #5 clk = ~clk;

  fuse_window #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
    .clk (clk), .rst (rst), .flush (flush),
    .alloc_valid (alloc_valid), .alloc_kind (alloc_kind), .alloc_tag (alloc_tag),
    .alloc_ready (alloc_ready),
    .issue_a_valid (issue_a_valid), .issue_a_idx (issue_a_idx), .issue_a_ready (issue_a_ready),
    .issue_b_valid (issue_b_valid), .issue_b_idx (issue_b_idx), .issue_b_ready (issue_b_ready),
    .complete_a_valid (complete_a_valid), .complete_a_idx (complete_a_idx),
    .complete_b_valid (complete_b_valid), .complete_b_idx (complete_b_idx),
    .retire_valid (retire_valid), .retire_tag (retire_tag), .retire_kind (retire_kind)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_alloc(input logic [1:0] kind, input logic [TAG_W-1:0] tag);
    while (!alloc_ready) step();
    alloc_valid = 1'b1;
    alloc_kind  = kind;
    alloc_tag   = tag;
    step();
    alloc_valid = 1'b0;
    exp_q.push_back({kind, tag});
  endtask

  task automatic accept(input bit a, input bit b);
    issue_a_ready = a;
    issue_b_ready = b;
    step();
    issue_a_ready = 1'b0;
    issue_b_ready = 1'b0;
  endtask

  task automatic complete(input bit a, input logic [IDX_W-1:0] xa,
                          input bit b, input logic [IDX_W-1:0] xb);
    complete_a_valid = a;
    complete_a_idx   = xa;
    complete_b_valid = b;
    complete_b_idx   = xb;
    step();
    complete_a_valid = 1'b0;
    complete_b_valid = 1'b0;
  endtask

  // Scoreboard monitor: R6 order, tag and kind of every retirement
  always @(negedge clk) begin
    if (!rst && retire_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected retire", int'(retire_tag), -1);
      end else begin
        logic [TAG_W+1:0] e;
        e = exp_q.pop_front();
        check(retire_tag == e[TAG_W-1:0], "R6 retire tag",
              int'(retire_tag), int'(e[TAG_W-1:0]));
        check(retire_kind == e[TAG_W+1:TAG_W], "R6 retire kind",
              int'(retire_kind), int'(e[TAG_W+1:TAG_W]));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R10 reset state
    check(alloc_ready == 1'b1, "R10 alloc_ready", int'(alloc_ready), 1);
    check(!issue_a_valid && !issue_b_valid, "R10 no issue",
          int'(issue_a_valid) + int'(issue_b_valid), 0);
    check(!retire_valid, "R10 no retire", int'(retire_valid), 0);

    // R3 fused store: both halves at once
    do_alloc(2'd1, 6'd5);
    check(issue_a_valid && issue_b_valid, "R3 store both halves offered",
          int'(issue_a_valid) + int'(issue_b_valid), 2);
    check(issue_a_idx == 0 && issue_b_idx == 0, "R3 store index",
          int'(issue_a_idx) + int'(issue_b_idx), 0);
    accept(1'b1, 1'b1);
    check(!issue_a_valid && !issue_b_valid, "R5 accepted halves not reoffered",
          int'(issue_a_valid) + int'(issue_b_valid), 0);
    complete(1'b1, 3'd0, 1'b0, 3'd0);
    check(!retire_valid, "R6 no retire with one half done", int'(retire_valid), 0);
    complete(1'b0, 3'd0, 1'b1, 3'd0);
    check(retire_valid, "R6 retire after both halves", int'(retire_valid), 1);
    step();
    check(!retire_valid, "R6 single retirement", int'(retire_valid), 0);

    // R4 load-op ordering
    do_alloc(2'd2, 6'd9);
    check(issue_a_valid && !issue_b_valid, "R4 only load half offered",
          int'(issue_b_valid), 0);
    accept(1'b1, 1'b0);
    check(!issue_b_valid, "R4 op half waits for load completion", int'(issue_b_valid), 0);
    complete(1'b1, 3'd1, 1'b0, 3'd0);
    check(issue_b_valid && issue_b_idx == 1, "R4 op half offered after load done",
          int'(issue_b_valid), 1);
    accept(1'b0, 1'b1);
    complete(1'b0, 3'd0, 1'b1, 3'd1);
    step();

    // R2 plain item
    do_alloc(2'd0, 6'd3);
    check(issue_a_valid && !issue_b_valid, "R2 plain only on port A",
          int'(issue_b_valid), 0);
    accept(1'b1, 1'b0);
    complete(1'b1, 3'd2, 1'b0, 3'd0);
    check(retire_valid, "R2 plain retires after first half", int'(retire_valid), 1);
    step();

    // R8 oldest first, R7 head blocking
    do_alloc(2'd0, 6'd11);
    do_alloc(2'd0, 6'd12);
    check(issue_a_idx == 3, "R8 oldest offered first", int'(issue_a_idx), 3);
    ia = issue_a_idx;
    accept(1'b1, 1'b0);
    check(issue_a_idx == 4, "R8 next entry offered", int'(issue_a_idx), 4);
    ib = issue_a_idx;
    accept(1'b1, 1'b0);
    complete(1'b1, ib, 1'b0, 3'd0);
    for (int n = 0; n < 3; n++) begin
      check(!retire_valid, "R7 unfinished head blocks", int'(retire_valid), 0);
      step();
    end
    complete(1'b1, ia, 1'b0, 3'd0);
    step();
    step();

    // R1 full stall
    for (int n = 0; n < DEPTH; n++) do_alloc(2'd0, TAG_W'(20 + n));
    check(!alloc_ready, "R1 alloc_ready low when full", int'(alloc_ready), 0);

    // R9 flush (head unissued, so nothing retires this cycle)
    flush = 1'b1;
    step();
    flush = 1'b0;
    exp_q.delete();
    check(alloc_ready, "R9 ready after flush", int'(alloc_ready), 1);
    check(!issue_a_valid && !retire_valid, "R9 nothing offered after flush",
          int'(issue_a_valid) + int'(retire_valid), 0);
    do_alloc(2'd1, 6'd40);
    check(issue_a_idx == 0, "R9 pointers reset", int'(issue_a_idx), 0);
    accept(1'b1, 1'b1);
    complete(1'b1, 3'd0, 1'b1, 3'd0);
    step();
    check(exp_q.size() == 0, "R6 all expected retirements seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule